// File: doc/BRIEF.md
# Byte ALU with Masked Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes an operation code and two operands (the second may be a register value or an immediate; the block does not distinguish them) and returns a combinational result together with a write-back enable. Six status flags are held in a register inside the block: carry, zero, negative, overflow, sign and half-carry. Every operation has a fixed mask that says which of these flags it rewrites. Flags outside that mask keep their stored value. The stored carry feeds the carry-using operations, and the stored zero flag feeds the chained-compare forms.

Compare operations compute a difference only to update the flags, so their write-back enable is low. Every operation finishes in one clock: the result is valid in the same cycle as the operation code, and the flags show the new values after the next rising edge.

Operation codes on `op_i`: 0 no-op, 1 add, 2 add with carry, 3 subtract, 4 subtract with carry, 5 AND, 6 OR, 7 XOR, 8 one's complement, 9 negate, 10 increment, 11 decrement, 12 shift left, 13 logical shift right, 14 rotate left through carry, 15 rotate right through carry, 16 arithmetic shift right, 17 nibble swap, 18 set all ones, 19 compare, 20 compare with carry, 21 clear. Codes 22 to 31 act as the no-op. Flag bits on `flags_o`: [0] C, [1] Z, [2] N, [3] V, [4] S, [5] H.

Top module: `byte_alu_core`

## Requirements
- R1: While reset is asserted, and after it is released, `flags_o` reads 0 until the first operation updates it.
- R2: Add (1) and add with carry (2) return (a + b + cin) mod 256, where cin is the stored C for code 2 and 0 for code 1. On the next edge they set C to the carry out of bit 7, H to the carry out of bit 3, V to the signed overflow, N to result bit 7, Z when the result is 0, and S.
- R3: Subtract (3), subtract with carry (4) and negate (9) return x − y − cin mod 256, with x=a and y=b for codes 3 and 4, and x=0 and y=a for code 9. cin is the stored C for code 4 and 0 otherwise. C is the borrow out of bit 7, H is the borrow out of the low nibble, V is the signed overflow, N is bit 7, Z is set when the result is 0, and S is updated.
- R4: For subtract with carry (4) and compare with carry (20), the new Z is 1 only when the difference is 0 and the stored Z was 1.
- R5: AND (5), OR (6), XOR (7) and clear (21, result 0) set Z, N and S, clear V, and leave C and H unchanged.
- R6: Increment (10) and decrement (11) return a ± 1 mod 256. They set Z, N and S. V is 1 exactly when a is 0x7F for increment or 0x80 for decrement. C and H are unchanged.
- R7: One's complement (8) returns 0xFF − a, sets C to 1 and V to 0, updates Z, N and S, and leaves H unchanged.
- R8: Shift left (12) and logical shift right (13) fill the vacated bit with 0. Rotates (14, 15) fill it with the stored C. Arithmetic shift right (16) keeps bit 7. For all five, C takes the bit shifted out, V = N XOR C, Z, N and S are updated, and H is unchanged.
- R9: Nibble swap (17) exchanges the two halves of a, and set-all-ones (18) returns 0xFF. Neither changes any flag. The no-op (0) and codes 22 to 31 change no flag either.
- R10: Compare (19) and compare with carry (20) update all six flags exactly as subtract (3) and subtract with carry (4) do, and drive the write-back enable low.
- R11: The stored S always equals N XOR V.
- R12: `wr_en_o` is 1 for every operation except codes 0, 19, 20 and 22 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | First operand (destination value) |
| opb_i | input | 8 | Second operand (register or immediate) |
| res_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Result is to be written back |
| flags_o | output | 6 | Stored flags {H,S,V,N,Z,C} |

## Verification
The result and the write-back enable depend only on the inputs and the stored flags, so they are due in the same cycle as the operation. The bench drives each vector just after a falling edge and samples `res_o` and `wr_en_o` one nanosecond later. The flags for that operation are due after the following rising edge, so the bench compares them at the next falling edge, before it drives the next vector. Each vector therefore starts from the flags its predecessor left behind, which carries varied stored C and Z values into the carry and chained-compare forms.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADC  = 5'd2,
        OP_SUB  = 5'd3,
        OP_SBC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_COM  = 5'd8,
        OP_NEG  = 5'd9,
        OP_INC  = 5'd10,
        OP_DEC  = 5'd11,
        OP_LSL  = 5'd12,
        OP_LSR  = 5'd13,
        OP_ROL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_ASR  = 5'd16,
        OP_SWAP = 5'd17,
        OP_SER  = 5'd18,
        OP_CMP  = 5'd19,
        OP_CPC  = 5'd20,
        OP_CLR  = 5'd21
    } alu_op_e;

    localparam int FLAG_N = 6;

    // bit order: [5] h, [4] s, [3] v, [2] n, [1] z, [0] c
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    localparam logic [FLAG_N-1:0] MASK_ALL   = 6'b111111;
    localparam logic [FLAG_N-1:0] MASK_ZCNVS = 6'b011111;
    localparam logic [FLAG_N-1:0] MASK_ZNVS  = 6'b011110;
    localparam logic [FLAG_N-1:0] MASK_NONE  = 6'b000000;

    function automatic logic [FLAG_N-1:0] flag_mask(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_NEG, OP_CMP, OP_CPC:          return MASK_ALL;
            OP_AND, OP_OR, OP_XOR, OP_CLR,
            OP_INC, OP_DEC:                  return MASK_ZNVS;
            OP_COM, OP_LSL, OP_LSR, OP_ROL,
            OP_ROR, OP_ASR:                  return MASK_ZCNVS;
            default:                         return MASK_NONE;
        endcase
    endfunction

    function automatic logic writes_back(alu_op_e op);
        case (op)
            OP_NOP, OP_CMP, OP_CPC: return 1'b0;
            default:                return (op <= OP_CLR);
        endcase
    endfunction

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              half_o,
    output logic              ovf_o
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W:0] full;
    logic [HALF:0]   low;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, x_i} - {1'b0, y_i} - {{DATA_W{1'b0}}, cin_i};
            low  = {1'b0, x_i[HALF-1:0]} - {1'b0, y_i[HALF-1:0]} - {{HALF{1'b0}}, cin_i};
        end else begin
            full = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
            low  = {1'b0, x_i[HALF-1:0]} + {1'b0, y_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
        end
        sum_o   = full[DATA_W-1:0];
        carry_o = full[DATA_W];
        half_o  = low[HALF];
        if (sub_i)
            ovf_o = (x_i[MSB] != y_i[MSB]) && (full[MSB] != x_i[MSB]);
        else
            ovf_o = (x_i[MSB] == y_i[MSB]) && (full[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  res_o = ~a_i;
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
            OP_SER:  res_o = '1;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        case (op_i)
            OP_LSL: begin res_o = {a_i[MSB-1:0], 1'b0};  cout_o = a_i[MSB]; end
            OP_LSR: begin res_o = {1'b0, a_i[MSB:1]};    cout_o = a_i[0];   end
            OP_ROL: begin res_o = {a_i[MSB-1:0], cin_i}; cout_o = a_i[MSB]; end
            OP_ROR: begin res_o = {cin_i, a_i[MSB:1]};   cout_o = a_i[0];   end
            OP_ASR: begin res_o = {a_i[MSB], a_i[MSB:1]}; cout_o = a_i[0];  end
            default: ;
        endcase
    end
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [FLAG_N-1:0] flags_o
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        alu_flags_t flags;
    } state_t;

    state_t st_d, st_q;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // adder/subtractor operand routing
    logic [DATA_W-1:0] ax, ay, asum;
    logic              acin, asub, acarry, ahalf, aovf;

    always_comb begin
        ax   = opa_i;
        ay   = opb_i;
        acin = 1'b0;
        asub = 1'b0;
        case (op)
            OP_ADC:         acin = st_q.flags.c;
            OP_SUB, OP_CMP: asub = 1'b1;
            OP_SBC, OP_CPC: begin asub = 1'b1; acin = st_q.flags.c; end
            OP_NEG:         begin ax = '0; ay = opa_i; asub = 1'b1; end
            OP_INC:         ay = ONE;
            OP_DEC:         begin ay = ONE; asub = 1'b1; end
            default: ;
        endcase
    end

    byte_alu_addsub #(.DATA_W(DATA_W)) i_addsub (
        .x_i(ax), .y_i(ay), .cin_i(acin), .sub_i(asub),
        .sum_o(asum), .carry_o(acarry), .half_o(ahalf), .ovf_o(aovf)
    );

    logic [DATA_W-1:0] lres;
    byte_alu_logic #(.DATA_W(DATA_W)) i_logic (
        .op_i(op), .a_i(opa_i), .b_i(opb_i), .res_o(lres)
    );

    logic [DATA_W-1:0] sres;
    logic              scout;
    byte_alu_shift #(.DATA_W(DATA_W)) i_shift (
        .op_i(op), .a_i(opa_i), .cin_i(st_q.flags.c), .res_o(sres), .cout_o(scout)
    );

    // result select and candidate flags
    logic [DATA_W-1:0] res;
    alu_flags_t        cand;

    always_comb begin
        res  = '0;
        cand = st_q.flags;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
            OP_INC, OP_DEC, OP_CMP, OP_CPC: begin
                res    = asum;
                cand.c = acarry;
                cand.h = ahalf;
                cand.v = aovf;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res    = sres;
                cand.c = scout;
            end
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_SWAP, OP_SER, OP_CLR: begin
                res    = lres;
                cand.v = 1'b0;
                if (op == OP_COM) cand.c = 1'b1;
            end
            default: ;
        endcase
        cand.n = res[MSB];
        cand.z = ~|res;
        if (op == OP_SBC || op == OP_CPC) cand.z = cand.z & st_q.flags.z;
        if (op inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR})
            cand.v = cand.n ^ cand.c;
        cand.s = cand.n ^ cand.v;
    end

    // per-flag write masking
    logic [FLAG_N-1:0] mask, cand_v, old_v, merged;
    assign mask   = flag_mask(op);
    assign cand_v = cand;
    assign old_v  = st_q.flags;

    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
        assign merged[gi] = mask[gi] ? cand_v[gi] : old_v[gi];
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = alu_flags_t'(merged);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o   = res;
    assign wr_en_o = writes_back(op);
    assign flags_o = st_q.flags;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        op_i,
    input logic [DATA_W-1:0] res_o,
    input logic              wr_en_o,
    input logic [FLAG_N-1:0] flags_o
);
    p_hold_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SWAP || op_i == OP_SER || op_i == OP_NOP) |=> $stable(flags_o));

    p_cmp_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP || op_i == OP_CPC) |-> !wr_en_o);

    p_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[4] == (flags_o[2] ^ flags_o[3]));

    p_keep_ch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_CLR)
        |=> $stable({flags_o[5], flags_o[0]}));

    p_z_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_CPC || op_i == OP_SBC) && !flags_o[1]) |=> !flags_o[1]);

    p_shift_n_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LSL || op_i == OP_ROR || op_i == OP_ASR)
        |=> flags_o[2] == $past(res_o[DATA_W-1]));

    p_com_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_COM) |=> (flags_o[0] && !flags_o[3]));
endmodule

bind byte_alu_core byte_alu_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .res_o(res_o),
    .wr_en_o(wr_en_o), .flags_o(flags_o)
);

// File: tb/test_byte_alu_core.sv
module test_byte_alu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = 5'd0;
    logic [7:0] opa_i = 8'd0;
    logic [7:0] opb_i = 8'd0;
    logic [7:0] res_o;
    logic       wr_en_o;
    logic [5:0] flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    byte_alu_core i_byte_alu_core (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            1, 2:             return "R2";
            3, 9:             return "R3";
            4, 20:            return "R4";
            5, 6, 7, 21:      return "R5";
            10, 11:           return "R6";
            8:                return "R7";
            12, 13, 14, 15, 16: return "R8";
            19:               return "R10";
            default:          return "R9";
        endcase
    endfunction

    function automatic int bpick(input int k);
        case (k)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
            4: return 8'h7F;  5: return 8'h80;  6: return 8'hFF;  7: return 8'h55;
            8: return 8'hAA;  9: return 8'h08;  10: return 8'hF0; 11: return 8'h81;
            12: return 8'h3C; 13: return 8'hFE; 14: return 8'h7E; default: return 8'h21;
        endcase
    endfunction

    // expected behaviour from the requirements
    task automatic model(input int op, input int a, input int b, input logic [5:0] f,
                         output int r, output bit wr, output logic [5:0] nf);
        int ci, x, y, d, lo, sv;
        bit c, z, n, v, h, s, uc, uz, un, uv, uh;
        c = f[0]; z = f[1]; n = f[2]; v = f[3]; s = f[4]; h = f[5];
        uc = 0; uz = 0; un = 0; uv = 0; uh = 0;
        r = 0; wr = 1;
        case (op)
            1, 2: begin
                ci = (op == 2) ? int'(c) : 0;
                d = a + b + ci; r = d & 255;
                c = d > 255; h = ((a & 15) + (b & 15) + ci) > 15;
                sv = sx(a) + sx(b) + ci; v = (sv > 127) || (sv < -128);
                uc = 1; uh = 1; uv = 1; uz = 1; un = 1;
                z = (r == 0);
            end
            3, 4, 9, 19, 20: begin
                ci = (op == 4 || op == 20) ? int'(c) : 0;
                x = (op == 9) ? 0 : a; y = (op == 9) ? a : b;
                d = x - y - ci; r = d & 255;
                c = d < 0; lo = (x & 15) - (y & 15) - ci; h = lo < 0;
                sv = sx(x) - sx(y) - ci; v = (sv > 127) || (sv < -128);
                z = (op == 4 || op == 20) ? ((r == 0) && z) : (r == 0);
                uc = 1; uh = 1; uv = 1; uz = 1; un = 1;
                if (op >= 19) wr = 0;
            end
            5, 6, 7, 21: begin
                r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (op == 7) ? (a ^ b) : 0;
                v = 0; z = (r == 0); uv = 1; uz = 1; un = 1;
            end
            10, 11: begin
                r = ((op == 10) ? a + 1 : a - 1) & 255;
                v = (op == 10) ? (a == 127) : (a == 128);
                z = (r == 0); uv = 1; uz = 1; un = 1;
            end
            8: begin
                r = 255 - a; c = 1; v = 0; z = (r == 0);
                uc = 1; uv = 1; uz = 1; un = 1;
            end
            12, 13, 14, 15, 16: begin
                case (op)
                    12: begin r = (a * 2) & 255;           c = a >= 128; end
                    13: begin r = a / 2;                   c = a % 2;    end
                    14: begin r = ((a * 2) & 255) + int'(c); c = a >= 128; end
                    15: begin r = a / 2 + (c ? 128 : 0);   c = a % 2;    end
                    default: begin r = a / 2 + (a & 128);  c = a % 2;    end
                endcase
                n = r >= 128; v = n ^ c; z = (r == 0);
                uc = 1; uv = 1; uz = 1; un = 1;
            end
            17: r = ((a & 15) * 16) + (a / 16);
            18: r = 255;
            default: wr = 0;
        endcase
        if (un) n = r >= 128;
        if (un) s = n ^ v;
        nf = {h, s, v, n, z, c};
        if (!uh) nf[5] = f[5];
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] fm, nf;
        int  r;
        bit  wr;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "flags in reset", int'(flags_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after release", int'(flags_o), 0);
        fm = 6'd0;

        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 16; k++) begin
                for (int op = 0; op < 24; op++) begin
                    int opc;
                    opc = (op == 22) ? 27 : (op == 23) ? 0 : op;
                    op_i  = opc[4:0];
                    opa_i = a[7:0];
                    opb_i = bpick(k);
                    model(opc, a, bpick(k), fm, r, wr, nf);
                    #1;
                    check("R12", "write enable", int'(wr_en_o), int'(wr));
                    if (wr) check(tag_of(opc), "result", int'(res_o), r);
                    @(negedge clk);
                    check(tag_of(opc), "flags", int'(flags_o), int'(nf));
                    check("R11", "S vs N^V", int'(flags_o[4]), int'(flags_o[2] ^ flags_o[3]));
                    fm = nf;
                end
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule